// File: doc/BRIEF.md
# Center-aligned three-phase PWM timer

This block produces three complementary pairs of raw PWM signals from one shared up/down period counter. The counter climbs from zero to one below the programmed half-period length, repeats that value, and then counts back to zero. Each pair compares the counter against its own duty value, with a programmable dead time, so the high-side and low-side signals of a pair are never active together. Active pulses shorter than a programmable minimum are dropped for that half period.

Software writes period, dead time, minimum pulse, three duty values, sync width and the update mode through a plain write strobe with an address. Every write lands in a shadow copy. The shadow copy is moved into the working set at the start of a period. In double update mode the duty values are also moved at the midpoint, which allows asymmetric waveforms. A sync pulse of programmable width marks each period start, and in double update mode each midpoint as well. A half flag reports which half of the period is running.

A synchronous request from external shutdown logic parks the counter and silences every output. When the request is released, the block restarts at a clean period start.

Top module: `cpwm_timer`

## Requirements
- R1: With half length P, the counter runs 0,1,…,P-1 upward and then P-1,…,0 downward, so one period lasts 2P cycles. `half_flag` is high during exactly the P downward cycles, and its falling edge marks a period start.
- R2: For pair k with duty D and dead time T, the high-side output is active while the counter is below D−T, and is never active when D≤T. The low-side output is active while the counter is at or above D+T. Over one period the high side is therefore active for 2·min(max(D−T,0),P) cycles and the low side for 2·max(P−(D+T),0) cycles.
- R3: The high-side and low-side outputs of a pair are never active in the same cycle.
- R4: The active width of an output within one half period is measured in cycles. If that width is nonzero but below the minimum pulse value, the output stays inactive for that half period. A minimum of 0 suppresses nothing.
- R5: In single update mode, writes have no effect on the outputs until the next period start. From that start on, the new values apply to the whole period, so the waveform is symmetric.
- R6: In double update mode, duty writes made during the first half take effect at that period's midpoint. The mode bit is data bit 0 at address 7 (1 selects double update mode). It takes effect at the next period start.
- R7: `sync_out` goes high in the period-start cycle and stays high for W cycles, where W is the sync width. In double update mode a second pulse of the same width starts in the first cycle of the downward half. A width of 0 acts as 1.
- R8: One cycle after `trip_rst` is sampled high, all raw outputs, `sync_out` and `half_flag` are low and remain low while the request is held. In the cycle after the request is sampled low, a new period begins, with `sync_out` high and `half_flag` low.
- R9: While `rst_n` is low, all outputs are low. Reset leaves period P=16, dead time 0, minimum pulse 0, all duty values 0, sync width 1 and single update mode.
- R10: The write address map is: 0 period P, 1 dead time, 2 minimum pulse, 3/4/5 duty of pairs 0/1/2, 6 sync width, 7 mode. A period write of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| trip_rst | input | 1 | Synchronous stop-and-restart request from shutdown logic |
| hi_raw | output | 3 | High-side raw signals, bit k is pair k |
| lo_raw | output | 3 | Low-side raw signals, bit k is pair k |
| sync_out | output | 1 | Sync pulse at period start and, in double update mode, at midpoint |
| half_flag | output | 1 | High in the second (downward) half of the period |

## Verification
The comparator path is driven by a table of duty, dead-time and minimum-pulse combinations that separate distinct behaviours:
- a centred duty, and a duty just above the dead time, which together distinguish the below and at-or-above comparisons;
- a sub-minimum pulse, which must disappear;
- a duty beyond the period, which must clip;
- zero duty, and a duty that equals the dead time, which must leave the high side silent.

Unequal duty values on the three pairs show that each address reaches its own pair. A duty write in the second half in single mode tells start-only reloading apart from midpoint reloading; the same write in the first half in double mode tells them apart the other way. Sync pulse counts per period separate single mode from double mode. A trip request made mid-period, followed by release, shows that the block goes quiet and then restarts at a clean period start.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W  = 16;
  localparam int NPH    = 3;
  localparam int ADDR_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [ADDR_W-1:0] {
    A_PER   = 3'd0,
    A_DEAD  = 3'd1,
    A_MINPW = 3'd2,
    A_DUTY0 = 3'd3,
    A_DUTY1 = 3'd4,
    A_DUTY2 = 3'd5,
    A_SYNCW = 3'd6,
    A_MODE  = 3'd7
  } addr_e;

  typedef struct packed {
    cnt_t                      per;
    cnt_t                      dt;
    cnt_t                      mpw;
    cnt_t                      sw;
    logic [NPH-1:0][CNT_W-1:0] duty;
    logic                      dbl;
  } cfg_t;

  // zero is replaced by one (period and sync width)
  function automatic cnt_t at_least_one(cnt_t v);
    return (v == '0) ? cnt_t'(1) : v;
  endfunction

  // high-side active cycles within one half period
  function automatic cnt_t hi_width(cnt_t duty, cnt_t dt, cnt_t per);
    cnt_t w;
    if (duty <= dt) return '0;
    w = duty - dt;
    return (w > per) ? per : w;
  endfunction

  // low-side active cycles within one half period
  function automatic cnt_t lo_width(cnt_t duty, cnt_t dt, cnt_t per);
    logic [CNT_W:0] s;
    s = {1'b0, duty} + {1'b0, dt};
    if (s >= {1'b0, per}) return '0;
    return per - s[CNT_W-1:0];
  endfunction

  // a pulse survives when it exists and meets the minimum
  function automatic logic pulse_ok(cnt_t w, cnt_t mpw);
    return (w != '0) && (w >= mpw);
  endfunction
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int DEF_PER = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  cnt_t              wr_data,
  input  logic              ld_start,
  input  logic              ld_mid,
  output cfg_t              act
);
  cfg_t shd;
  cfg_t dflt;

  always_comb begin
    dflt     = '0;
    dflt.per = at_least_one(cnt_t'(DEF_PER));
    dflt.sw  = cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= dflt;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_PER:   shd.per <= at_least_one(wr_data);
        A_DEAD:  shd.dt  <= wr_data;
        A_MINPW: shd.mpw <= wr_data;
        A_SYNCW: shd.sw  <= at_least_one(wr_data);
        A_MODE:  shd.dbl <= wr_data[0];
        default: begin
          for (int p = 0; p < NPH; p++)
            if (wr_addr == ADDR_W'(int'(A_DUTY0) + p)) shd.duty[p] <= wr_data;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act      <= dflt;
    else if (ld_start) act      <= shd;
    else if (ld_mid)   act.duty <= shd.duty;
  end
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  input  cnt_t per,
  input  logic dbl,
  input  cnt_t sw,
  output cnt_t cnt,
  output logic down,
  output logic hold,
  output logic start_evt,
  output logic mid_evt,
  output logic ld_start,
  output logic ld_mid,
  output logic sync
);
  cnt_t scnt;
  logic last_up;
  logic last_dn;

  assign last_up   = !down && (cnt == per - 1'b1);
  assign last_dn   = down && (cnt == '0);
  assign start_evt = !hold && !down && (cnt == '0);
  assign mid_evt   = !hold && dbl && down && (cnt == per - 1'b1);
  assign ld_start  = rst_req || hold || last_dn;
  assign ld_mid    = !hold && dbl && last_up;
  assign sync      = start_evt || mid_evt || (scnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
      hold <= 1'b1;
    end else begin
      hold <= rst_req;
      if (rst_req || hold) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (last_up) begin
        down <= 1'b1;
      end else if (last_dn) begin
        down <= 1'b0;
      end else if (down) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      scnt <= '0;
    else if (rst_req || hold)        scnt <= '0;
    else if (start_evt || mid_evt)   scnt <= sw - 1'b1;
    else if (scnt != '0)             scnt <= scnt - 1'b1;
  end
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase
  import cpwm_pkg::*;
(
  input  cnt_t cnt,
  input  cnt_t duty,
  input  cnt_t dt,
  input  cnt_t mpw,
  input  cnt_t per,
  input  logic hold,
  output logic hi,
  output logic lo
);
  cnt_t hw;
  cnt_t lw;
  logic hw_keep;
  logic lw_keep;

  assign hw      = hi_width(duty, dt, per);
  assign lw      = lo_width(duty, dt, per);
  assign hw_keep = pulse_ok(hw, mpw);
  assign lw_keep = pulse_ok(lw, mpw);
  assign hi      = !hold && hw_keep && (cnt < hw);
  assign lo      = !hold && lw_keep && (cnt >= per - lw);
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int DEF_PER = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              trip_rst,
  output logic [NPH-1:0]    hi_raw,
  output logic [NPH-1:0]    lo_raw,
  output logic              sync_out,
  output logic              half_flag
);
  cfg_t act;
  cnt_t cnt_w;
  cnt_t per_w;
  logic down_w;
  logic hold_w;
  logic start_w;
  logic mid_w;
  logic ld_start_w;
  logic ld_mid_w;

  assign per_w = act.per;

  cpwm_regs #(.DEF_PER(DEF_PER)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ld_start(ld_start_w), .ld_mid(ld_mid_w), .act(act)
  );

  cpwm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .rst_req(trip_rst), .per(act.per),
    .dbl(act.dbl), .sw(act.sw), .cnt(cnt_w), .down(down_w), .hold(hold_w),
    .start_evt(start_w), .mid_evt(mid_w), .ld_start(ld_start_w),
    .ld_mid(ld_mid_w), .sync(sync_out)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    cpwm_phase u_ph (
      .cnt(cnt_w), .duty(act.duty[p]), .dt(act.dt), .mpw(act.mpw),
      .per(act.per), .hold(hold_w), .hi(hi_raw[p]), .lo(lo_raw[p])
    );
  end

  assign half_flag = down_w;
endmodule

// File: rtl/cpwm_timer_chk.sv
module cpwm_timer_chk
  import cpwm_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           trip_rst,
  input logic [NPH-1:0] hi_raw,
  input logic [NPH-1:0] lo_raw,
  input logic           sync_out,
  input logic           half_flag,
  input cnt_t           cnt,
  input cnt_t           per,
  input logic           hold
);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_raw & lo_raw) == '0);

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per);

  a_r1_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt))
              || (cnt == $past(cnt) - 1'b1) || (cnt == '0));

  a_r7_start_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(half_flag) && !$past(trip_rst)) |-> sync_out);

  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    trip_rst |=> (hi_raw == '0) && (lo_raw == '0) && !sync_out && !half_flag);

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_rst) |=> sync_out && !half_flag);
endmodule

bind cpwm_timer cpwm_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trip_rst(trip_rst), .hi_raw(hi_raw),
  .lo_raw(lo_raw), .sync_out(sync_out), .half_flag(half_flag),
  .cnt(cnt_w), .per(per_w), .hold(hold_w)
);

// File: tb/cpwm_timer_bench.sv
module cpwm_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 20;
  localparam int NVEC       = 7;
  // {duty, dead, minpw, exp hi cycles per period, exp lo cycles per period}
  localparam logic [79:0] VEC [NVEC] = '{
    {16'd10, 16'd2, 16'd0, 16'd16, 16'd16},
    {16'd3,  16'd2, 16'd0, 16'd2,  16'd30},
    {16'd3,  16'd2, 16'd2, 16'd0,  16'd30},
    {16'd25, 16'd2, 16'd0, 16'd40, 16'd0 },
    {16'd0,  16'd0, 16'd0, 16'd0,  16'd40},
    {16'd19, 16'd0, 16'd2, 16'd38, 16'd0 },
    {16'd2,  16'd2, 16'd0, 16'd0,  16'd32}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trip_rst = 1'b0;
  logic [2:0]  hi_raw, lo_raw;
  logic        sync_out, half_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int n_hi [3];
  int n_lo [3];
  int n_sync, n_half, n_overlap, n_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_timer u_cpwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trip_rst(trip_rst), .hi_raw(hi_raw),
    .lo_raw(lo_raw), .sync_out(sync_out), .half_flag(half_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // leaves the bench at the negedge of a period-start cycle
  task automatic wait_start();
    @(negedge clk);
    while (!half_flag) @(negedge clk);
    while (half_flag) @(negedge clk);
  endtask

  // counts activity over one period of 2*len cycles from a start cycle
  task automatic run_period(input int len);
    for (int p = 0; p < 3; p++) begin n_hi[p] = 0; n_lo[p] = 0; end
    n_sync = 0; n_half = 0; n_overlap = 0;
    for (int i = 0; i < 2*len; i++) begin
      for (int p = 0; p < 3; p++) begin
        n_hi[p] += int'(hi_raw[p]);
        n_lo[p] += int'(lo_raw[p]);
      end
      n_sync += int'(sync_out);
      n_half += int'(half_flag);
      if ((hi_raw & lo_raw) != 3'b0) n_overlap++;
      @(negedge clk);
    end
  endtask

  // one period with a duty-0 write at cycle 'at', counting hi of pair 0 from 'from'
  task automatic period_with_write(input int at, input int d, input int from);
    n_sel = 0;
    for (int i = 0; i < 2*P; i++) begin
      if (i == at) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'(d); end
      if (i == at + 1) wr_en = 1'b0;
      if (i >= from) n_sel += int'(hi_raw[0]);
      @(negedge clk);
    end
  endtask

  task automatic set_duty_all(input int d);
    wr(3, d); wr(4, d); wr(5, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: outputs quiet during reset
    repeat (3) @(negedge clk);
    chk("R9 hi in reset", int'(hi_raw), 0);
    chk("R9 lo in reset", int'(lo_raw), 0);
    chk("R9 sync/half in reset", int'({sync_out, half_flag}), 0);
    rst_n = 1'b1;

    // R9 defaults, R1 half length, R7 width 1
    wait_start();
    run_period(16);
    chk("R1 half length default", n_half, 16);
    chk("R9 default lo pair0", n_lo[0], 32);
    chk("R9 default hi pair0", n_hi[0], 0);
    chk("R7 default sync width", n_sync, 1);

    // R10 period and sync width, unequal duties per address
    wr(0, P); wr(6, 3); wr(3, 10); wr(4, 4); wr(5, 16);
    wait_start();
    run_period(P);
    chk("R1 half length", n_half, P);
    chk("R10 pair0 duty addr", n_hi[0], 20);
    chk("R10 pair1 duty addr", n_hi[1], 8);
    chk("R10 pair2 duty addr", n_hi[2], 32);
    chk("R7 single sync width", n_sync, 3);

    // R2/R3/R4 vector table
    for (int v = 0; v < NVEC; v++) begin
      wr(1, int'(VEC[v][63:48]));
      wr(2, int'(VEC[v][47:32]));
      set_duty_all(int'(VEC[v][79:64]));
      wait_start();
      run_period(P);
      for (int p = 0; p < 3; p++) begin
        chk($sformatf("R2/R4 vec%0d hi pair%0d", v, p), n_hi[p], int'(VEC[v][31:16]));
        chk($sformatf("R2/R4 vec%0d lo pair%0d", v, p), n_lo[p], int'(VEC[v][15:0]));
      end
      chk($sformatf("R3 vec%0d overlap cycles", v), n_overlap, 0);
    end

    // R5 single update: second-half write waits for next start
    wr(1, 0); wr(2, 0); set_duty_all(10);
    wait_start();
    period_with_write(22, 4, 24);
    chk("R5 late-half hi keeps old duty", n_sel, 10);
    run_period(P);
    chk("R5 new duty at next start", n_hi[0], 8);

    // R6/R7 double update
    set_duty_all(10); wr(7, 1);
    wait_start();
    run_period(P);
    chk("R7 double sync width x2", n_sync, 6);
    chk("R6 symmetric before write", n_hi[0], 20);
    period_with_write(2, 4, 20);
    chk("R6 midpoint reload", n_sel, 4);

    // R8 trip request mid-period
    wr(7, 0); set_duty_all(10);
    wait_start();
    repeat (5) @(negedge clk);
    trip_rst = 1'b1;
    @(negedge clk);
    chk("R8 quiet outputs", int'({hi_raw, lo_raw, sync_out, half_flag}), 0);
    repeat (3) @(negedge clk);
    chk("R8 still quiet", int'({hi_raw, lo_raw, sync_out, half_flag}), 0);
    trip_rst = 1'b0;
    @(negedge clk);
    chk("R8 restart sync/half", int'({sync_out, half_flag}), 2);
    run_period(P);
    chk("R8 full period after restart", n_hi[0], 20);

    // R10/R7 zero period and zero sync width act as 1
    wr(0, 0); wr(6, 0);
    wait_start();
    run_period(1);
    chk("R10 period zero half", n_half, 1);
    chk("R7 sync width zero", n_sync, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule